// File: doc/BRIEF.md
# Two-Level I/O Address Translation Walker

This block turns a 32-bit I/O virtual address (IOVA) into a 40-bit physical address. It does this by walking a two-level table held in system memory. A client presents an IOVA and a write flag on a valid/ready request port. The block then works through these steps:

1. It takes the directory base from a root pointer input.
2. It fetches one directory entry over a 32-bit read port with valid/ready handshakes.
3. It fetches one leaf entry over the same port.
4. It returns a one-cycle response. The response carries either the physical address, or a fault flag with a cause code. The IOVA of the request is echoed with every response.

A small fully associative cache of leaf entries sits in front of the walk. A translation that hits in it needs no memory access. A flush pulse empties the cache.

The block serves one request at a time. It drops its request-ready signal from the cycle after it accepts a request until the cycle in which the response is shown. Fault causes are encoded as follows: 1 = directory entry invalid, 2 = leaf entry invalid, 3 = write to a read-only page, 4 = root pointer mode field nonzero. On a good translation the cause is 0.

Top module: `iova_walker`

## Requirements
- R1: The first memory read of a walk is at address {root[31:10], 10'b0} + 4 * IOVA[31:22].
- R2: The second read is at (directory entry AND 0xFFFFFFC0) + 4 * IOVA[21:12].
- R3: A directory entry with bit 0 clear ends the walk after that single read. The response has fault=1, cause=1, pa=0 and carries the request IOVA.
- R4: A leaf entry with bit 0 clear ends the walk with fault=1, cause=2 and pa=0.
- R5: On success the result is pa = {leaf[11:4], leaf[31:12], IOVA[11:0]} with fault=0 and cause=0.
- R6: A write request whose leaf has bit 2 clear faults with cause=3. This holds both on a walk and on a cache hit. A read request to the same page succeeds.
- R7: When the root pointer bits 9:0 are nonzero, the request faults with cause=4 and makes no memory read.
- R8: A request to a page whose valid leaf is cached is answered with no memory read.
- R9: The cache holds 4 entries, filled in round-robin order. After 5 distinct pages have been walked, the first of them walks again and the second still hits.
- R10: A flush pulse empties the cache on the next clock edge, so the next request to a previously cached page walks again.
- R11: Request-ready is low from the cycle after acceptance until the response. Exactly one single-cycle response is given per accepted request.
- R12: While a memory read request is valid and not ready, it stays valid and its address does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| root_ptr_i | input | 32 | Root pointer: directory base in bits 31:10, mode field in bits 9:0 (must be 0) |
| flush_i | input | 1 | Pulse that invalidates every cache entry |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_iova_i | input | 32 | IOVA to translate |
| req_write_i | input | 1 | Request is a write access |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_fault_o | output | 1 | Translation failed |
| rsp_cause_o | output | 3 | Fault cause code (0 when there is no fault) |
| rsp_pa_o | output | 40 | Physical address (0 on a fault) |
| rsp_iova_o | output | 32 | IOVA of the request being answered |
| mem_req_valid_o | output | 1 | Memory read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the read request |
| mem_addr_o | output | 32 | Word address of the read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Read data |

## Verification
A corrupted cache entry or a round-robin pointer in the wrong place shows up as the wrong number of memory reads for a request. It can also show up as a physical address taken from another page. Either is seen in the very response to that request, or only once a fifth page forces an eviction. A wrong walk state shows up as an address at the memory port that is off by a table index or by the masked directory bits. A lost response holds request-ready low, which the bench reports on its next request. The bench therefore counts reads per request and records their addresses, in addition to checking the response fields.

// File: rtl/iova_walk_pkg.sv
package iova_walk_pkg;
  localparam int unsigned VA_W   = 32;
  localparam int unsigned PA_W   = 40;
  localparam int unsigned VPN_W  = 20;
  localparam int unsigned OFF_W  = 12;
  localparam int unsigned IDX_W  = 10;
  localparam logic [31:0] DTE_BASE_MASK = 32'hFFFF_FFC0;

  typedef enum logic [2:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_DIR  = 3'd1,
    CAUSE_LEAF = 3'd2,
    CAUSE_PERM = 3'd3,
    CAUSE_ROOT = 3'd4
  } cause_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOK, ST_DIR_REQ, ST_DIR_WAIT, ST_PT_REQ, ST_PT_WAIT
  } walk_st_e;

  // leaf bits 11:4 hold physical bits 39:32
  function automatic logic [PA_W-1:0] leaf_to_pa(input logic [31:0] leaf,
                                                 input logic [OFF_W-1:0] off);
    return {leaf[11:4], leaf[31:12], off};
  endfunction
endpackage

// File: rtl/leaf_cache.sv
module leaf_cache #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned TAG_W   = 20,
  parameter int unsigned DATA_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [TAG_W-1:0]  look_tag_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] hit_data_o,
  input  logic              fill_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic [DATA_W-1:0] fill_data_i
);
  localparam int unsigned PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]  valid_q;
  logic [TAG_W-1:0]    tag_q  [ENTRIES];
  logic [DATA_W-1:0]   data_q [ENTRIES];
  logic [ENTRIES-1:0]  match;
  logic [PTR_W-1:0]    ptr_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign match[g] = valid_q[g] && (tag_q[g] == look_tag_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        tag_q[g]   <= '0;
        data_q[g]  <= '0;
      end else if (flush_i) begin
        valid_q[g] <= 1'b0;
      end else if (fill_i && (ptr_q == PTR_W'(g))) begin
        valid_q[g] <= 1'b1;
        tag_q[g]   <= fill_tag_i;
        data_q[g]  <= fill_data_i;
      end
    end
  end

  always_comb begin
    hit_data_o = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match[i]) hit_data_o = hit_data_o | data_q[i];
  end
  assign hit_o = |match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      ptr_q <= '0;
    else if (fill_i && !flush_i)
      ptr_q <= (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
  end

  // R10
  flush_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_q == '0));
  // R9
  single_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));
endmodule

// File: rtl/walk_fsm.sv
module walk_fsm
  import iova_walk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [31:0]      root_ptr_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_iova_i,
  input  logic             req_write_i,
  output logic             rsp_valid_o,
  output logic             rsp_fault_o,
  output logic [2:0]       rsp_cause_o,
  output logic [PA_W-1:0]  rsp_pa_o,
  output logic [VA_W-1:0]  rsp_iova_o,
  output logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  output logic [31:0]      mem_addr_o,
  input  logic             mem_rsp_valid_i,
  input  logic [31:0]      mem_rsp_data_i,
  output logic [VPN_W-1:0] look_tag_o,
  input  logic             hit_i,
  input  logic [31:0]      hit_leaf_i,
  output logic             fill_o,
  output logic [VPN_W-1:0] fill_tag_o,
  output logic [31:0]      fill_leaf_o
);
  walk_st_e          st_q;
  logic [VA_W-1:0]   iova_q;
  logic              wr_q;
  logic [31:0]       root_q;
  logic [31:0]       pt_base_q;
  logic              rsp_valid_q, rsp_fault_q;
  cause_e            rsp_cause_q;
  logic [PA_W-1:0]   rsp_pa_q;
  logic [31:0]       dir_addr, pt_addr;
  logic              accept;

  assign accept      = req_valid_i && req_ready_o;
  assign req_ready_o = (st_q == ST_IDLE);
  assign dir_addr    = {root_q[31:10], 10'b0} + {20'b0, iova_q[31:22], 2'b00};
  assign pt_addr     = pt_base_q + {20'b0, iova_q[21:12], 2'b00};
  assign mem_req_valid_o = (st_q == ST_DIR_REQ) || (st_q == ST_PT_REQ);
  assign mem_addr_o  = (st_q == ST_PT_REQ) ? pt_addr : dir_addr;
  assign look_tag_o  = iova_q[VA_W-1:OFF_W];
  assign fill_o      = (st_q == ST_PT_WAIT) && mem_rsp_valid_i && mem_rsp_data_i[0];
  assign fill_tag_o  = iova_q[VA_W-1:OFF_W];
  assign fill_leaf_o = mem_rsp_data_i;

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_fault_o = rsp_fault_q;
  assign rsp_cause_o = rsp_cause_q;
  assign rsp_pa_o    = rsp_pa_q;
  assign rsp_iova_o  = iova_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      iova_q      <= '0;
      wr_q        <= 1'b0;
      root_q      <= '0;
      pt_base_q   <= '0;
      rsp_valid_q <= 1'b0;
      rsp_fault_q <= 1'b0;
      rsp_cause_q <= CAUSE_NONE;
      rsp_pa_q    <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          iova_q <= req_iova_i;
          wr_q   <= req_write_i;
          root_q <= root_ptr_i;
          st_q   <= ST_LOOK;
        end
        ST_LOOK: begin
          if (root_q[9:0] != 10'd0) begin
            rsp_valid_q <= 1'b1; rsp_fault_q <= 1'b1;
            rsp_cause_q <= CAUSE_ROOT; rsp_pa_q <= '0;
            st_q <= ST_IDLE;
          end else if (hit_i) begin
            rsp_valid_q <= 1'b1;
            st_q <= ST_IDLE;
            if (wr_q && !hit_leaf_i[2]) begin
              rsp_fault_q <= 1'b1; rsp_cause_q <= CAUSE_PERM; rsp_pa_q <= '0;
            end else begin
              rsp_fault_q <= 1'b0; rsp_cause_q <= CAUSE_NONE;
              rsp_pa_q <= leaf_to_pa(hit_leaf_i, iova_q[OFF_W-1:0]);
            end
          end else begin
            st_q <= ST_DIR_REQ;
          end
        end
        ST_DIR_REQ: if (mem_req_ready_i) st_q <= ST_DIR_WAIT;
        ST_DIR_WAIT: if (mem_rsp_valid_i) begin
          if (!mem_rsp_data_i[0]) begin
            rsp_valid_q <= 1'b1; rsp_fault_q <= 1'b1;
            rsp_cause_q <= CAUSE_DIR; rsp_pa_q <= '0;
            st_q <= ST_IDLE;
          end else begin
            pt_base_q <= mem_rsp_data_i & DTE_BASE_MASK;
            st_q <= ST_PT_REQ;
          end
        end
        ST_PT_REQ: if (mem_req_ready_i) st_q <= ST_PT_WAIT;
        ST_PT_WAIT: if (mem_rsp_valid_i) begin
          rsp_valid_q <= 1'b1;
          st_q <= ST_IDLE;
          if (!mem_rsp_data_i[0]) begin
            rsp_fault_q <= 1'b1; rsp_cause_q <= CAUSE_LEAF; rsp_pa_q <= '0;
          end else if (wr_q && !mem_rsp_data_i[2]) begin
            rsp_fault_q <= 1'b1; rsp_cause_q <= CAUSE_PERM; rsp_pa_q <= '0;
          end else begin
            rsp_fault_q <= 1'b0; rsp_cause_q <= CAUSE_NONE;
            rsp_pa_q <= leaf_to_pa(mem_rsp_data_i, iova_q[OFF_W-1:0]);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R12
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_addr_o)));
  // R11
  busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !req_ready_o);
  // R11
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  // R3
  fault_pa_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o) |-> (rsp_pa_o == '0 && rsp_cause_o != CAUSE_NONE));
  // R5
  ok_offset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_fault_o) |-> (rsp_cause_o == CAUSE_NONE &&
                                       rsp_pa_o[OFF_W-1:0] == rsp_iova_o[OFF_W-1:0]));
  // R7
  root_nomem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o) |-> (root_q[9:0] == 10'd0));
endmodule

// File: rtl/iova_walker.sv
module iova_walker
  import iova_walk_pkg::*;
#(
  parameter int unsigned CACHE_ENTRIES = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] root_ptr_i,
  input  logic        flush_i,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic [31:0] req_iova_i,
  input  logic        req_write_i,
  output logic        rsp_valid_o,
  output logic        rsp_fault_o,
  output logic [2:0]  rsp_cause_o,
  output logic [39:0] rsp_pa_o,
  output logic [31:0] rsp_iova_o,
  output logic        mem_req_valid_o,
  input  logic        mem_req_ready_i,
  output logic [31:0] mem_addr_o,
  input  logic        mem_rsp_valid_i,
  input  logic [31:0] mem_rsp_data_i
);
  logic [VPN_W-1:0] look_tag, fill_tag;
  logic             hit, fill;
  logic [31:0]      hit_leaf, fill_leaf;

  walk_fsm u_walk (
    .clk_i, .rst_ni, .root_ptr_i,
    .req_valid_i, .req_ready_o, .req_iova_i, .req_write_i,
    .rsp_valid_o, .rsp_fault_o, .rsp_cause_o, .rsp_pa_o, .rsp_iova_o,
    .mem_req_valid_o, .mem_req_ready_i, .mem_addr_o,
    .mem_rsp_valid_i, .mem_rsp_data_i,
    .look_tag_o(look_tag), .hit_i(hit), .hit_leaf_i(hit_leaf),
    .fill_o(fill), .fill_tag_o(fill_tag), .fill_leaf_o(fill_leaf)
  );

  leaf_cache #(.ENTRIES(CACHE_ENTRIES), .TAG_W(VPN_W), .DATA_W(32)) u_cache (
    .clk_i, .rst_ni, .flush_i,
    .look_tag_i(look_tag), .hit_o(hit), .hit_data_o(hit_leaf),
    .fill_i(fill), .fill_tag_i(fill_tag), .fill_data_i(fill_leaf)
  );
endmodule

// File: tb/iova_walker_tb_top.sv
`timescale 1ns/1ps
module iova_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] root_ptr = 32'h0001_0000;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_iova = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid, rsp_fault;
  logic [2:0]  rsp_cause;
  logic [39:0] rsp_pa;
  logic [31:0] rsp_iova;
  logic        mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [31:0] mem_addr, mem_rsp_data;

  int unsigned n_tests = 0, n_fail = 0;
  int unsigned reads = 0, viol = 0, cyc = 0;
  logic [31:0] rd_addr [0:1];
  logic [31:0] mem_q [int unsigned];

  always #4 clk = ~clk;

  iova_walker dut_i (
    .clk_i(clk), .rst_ni(rst_n), .root_ptr_i(root_ptr), .flush_i(flush),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_iova_i(req_iova),
    .req_write_i(req_write), .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault),
    .rsp_cause_o(rsp_cause), .rsp_pa_o(rsp_pa), .rsp_iova_o(rsp_iova),
    .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready),
    .mem_addr_o(mem_addr), .mem_rsp_valid_i(mem_rsp_valid),
    .mem_rsp_data_i(mem_rsp_data)
  );

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    return mem_q.exists(a) ? mem_q[a] : 32'h0;
  endfunction

  // memory model with stall pattern
  logic        prev_stall = 1'b0;
  logic [31:0] prev_addr = '0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_req_ready <= ((cyc % 3) != 0);
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= mem_rd(mem_addr);
      if (reads < 2) rd_addr[reads] <= mem_addr;
      reads <= reads + 1;
    end else begin
      mem_rsp_valid <= 1'b0;
    end
    if (prev_stall && (!mem_req_valid || mem_addr != prev_addr)) viol <= viol + 1;
    prev_stall <= mem_req_valid && !mem_req_ready;
    prev_addr  <= mem_addr;
  end
  initial begin mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0; end

  task automatic check(input logic ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic        r_fault;
  logic [2:0]  r_cause;
  logic [39:0] r_pa;
  logic [31:0] r_iova;
  int unsigned r_reads;

  task automatic xlate(input logic [31:0] iova, input logic wr);
    int unsigned start, t;
    t = 0;
    @(negedge clk);
    while (!req_ready && t < 200) begin @(negedge clk); t++; end
    start = reads;
    req_valid = 1'b1; req_iova = iova; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready || rsp_valid, "R11 ready low after accept", {63'b0, req_ready}, 64'h0);
    t = 0;
    while (!rsp_valid && t < 200) begin @(negedge clk); t++; end
    check(rsp_valid, "R11 response arrives", {63'b0, rsp_valid}, 64'h1);
    r_fault = rsp_fault; r_cause = rsp_cause; r_pa = rsp_pa; r_iova = rsp_iova;
    r_reads = reads - start;
    @(negedge clk);
    check(!rsp_valid, "R11 single-cycle response", {63'b0, rsp_valid}, 64'h0);
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1; @(negedge clk); flush = 1'b0;
  endtask

  task automatic t_reset();
    check(req_ready == 1'b1, "reset ready", {63'b0, req_ready}, 64'h1);
    check(rsp_valid == 1'b0, "reset rsp_valid", {63'b0, rsp_valid}, 64'h0);
    check(mem_req_valid == 1'b0, "reset mem_req_valid", {63'b0, mem_req_valid}, 64'h0);
  endtask

  task automatic t_walk_ok();
    xlate(32'h0040_3123, 1'b1);
    check(r_fault == 0 && r_cause == 0, "R5 no fault", {61'b0, r_cause}, 64'h0);
    check(r_pa == 40'h5A_ABCD_E123, "R5 pa", {24'b0, r_pa}, 64'h5A_ABCD_E123);
    check(r_reads == 2, "R5 two reads", r_reads, 2);
    check(rd_addr[0] == 32'h0001_0004, "R1 dir addr", {32'b0, rd_addr[0]}, 64'h1_0004);
    check(rd_addr[1] == 32'h0002_004C, "R2 leaf addr", {32'b0, rd_addr[1]}, 64'h2_004C);
  endtask

  task automatic t_hit();
    xlate(32'h0040_3FFF, 1'b0);
    check(r_reads == 0, "R8 hit no read", r_reads, 0);
    check(r_pa == 40'h5A_ABCD_EFFF, "R8 hit pa", {24'b0, r_pa}, 64'h5A_ABCD_EFFF);
  endtask

  task automatic t_dir_fault();
    xlate(32'h0080_0ABC, 1'b0);
    check(r_fault && r_cause == 3'd1, "R3 cause", {61'b0, r_cause}, 64'h1);
    check(r_iova == 32'h0080_0ABC && r_pa == 0, "R3 iova/pa", {32'b0, r_iova}, 64'h80_0ABC);
    check(r_reads == 1, "R3 one read", r_reads, 1);
  endtask

  task automatic t_leaf_fault();
    xlate(32'h0040_7010, 1'b0);
    check(r_fault && r_cause == 3'd2 && r_pa == 0, "R4 cause", {61'b0, r_cause}, 64'h2);
    check(r_reads == 2, "R4 two reads", r_reads, 2);
  endtask

  task automatic t_perm();
    do_flush();
    xlate(32'h0040_5044, 1'b1);
    check(r_fault && r_cause == 3'd3, "R6 walk write", {61'b0, r_cause}, 64'h3);
    xlate(32'h0040_5044, 1'b0);
    check(!r_fault && r_pa == 40'h01_1234_5044, "R6 read ok", {24'b0, r_pa}, 64'h01_1234_5044);
    check(r_reads == 0, "R6 read hit", r_reads, 0);
    xlate(32'h0040_5044, 1'b1);
    check(r_fault && r_cause == 3'd3 && r_reads == 0, "R6 hit write", {61'b0, r_cause}, 64'h3);
  endtask

  task automatic t_root_mode();
    root_ptr = 32'h0001_0001;
    xlate(32'h0040_3123, 1'b0);
    check(r_fault && r_cause == 3'd4, "R7 cause", {61'b0, r_cause}, 64'h4);
    check(r_reads == 0, "R7 no read", r_reads, 0);
    root_ptr = 32'h0001_0000;
  endtask

  task automatic t_round_robin();
    do_flush();
    for (int p = 8; p < 13; p++) begin
      xlate({10'd1, 10'(p), 12'h010}, 1'b0);
      check(r_reads == 2 && r_pa == {8'h0, 20'(p), 12'h010}, "R9 fill walk", {24'b0, r_pa},
            {24'b0, 8'h0, 20'(p), 12'h010});
    end
    xlate({10'd1, 10'd9, 12'h0}, 1'b0);
    check(r_reads == 0, "R9 second page hits", r_reads, 0);
    xlate({10'd1, 10'd8, 12'h0}, 1'b0);
    check(r_reads == 2, "R9 first page evicted", r_reads, 2);
  endtask

  task automatic t_flush();
    xlate({10'd1, 10'd10, 12'h0}, 1'b0);
    check(r_reads == 0, "R10 pre-flush hit", r_reads, 0);
    do_flush();
    xlate({10'd1, 10'd10, 12'h0}, 1'b0);
    check(r_reads == 2, "R10 walk after flush", r_reads, 2);
  endtask

  initial begin
    mem_q[32'h0001_0004] = 32'h0002_007F;            // dte with junk low bits
    mem_q[32'h0002_004C] = 32'hABCD_E5A5;            // writable, hi=5A
    mem_q[32'h0002_0054] = 32'h1234_5011;            // read-only, hi=01
    for (int p = 8; p < 13; p++)
      mem_q[32'h0002_0040 + 32'(p) * 4] = (32'(p) << 12) | 32'h1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_walk_ok();
    t_hit();
    t_dir_fault();
    t_leaf_fault();
    t_perm();
    t_root_mode();
    t_round_robin();
    t_flush();
    check(viol == 0, "R12 address hold", viol, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule